// File: doc/BRIEF.md
# Atomic-Aware Memory Request Issuer

This block sits between a pipeline's memory stage and a ready/valid memory port. It takes one load or store request at a time and chooses the memory command from the request's atomic flags: a locked read becomes a load-linked, and a store with the swap flag becomes a swap. A store with only the locked flag becomes a store-conditional. It then drives the command, address and data to memory and reports completion back to the pipeline with a success flag and the returned data.

The block keeps one link reservation, made of a valid bit and a line address. A completed load-linked records the reservation. A store-conditional is sent to memory only if the reservation is valid and covers the same line. If not, it completes on its own with failure and never reaches the port. Any store-conditional clears the reservation, and so does an external clear input, which stands in for coherence traffic. If the port refuses a command, the block blocks and waits for a retry pulse before it sends again. A squash input abandons the current request, and a response that is still owed for a squashed request is consumed and dropped.

Top module: `mem_req_issuer`

## Requirements
- R1: A read request (reqWrite=0) is issued as command code 2 (load-linked) when reqLocked is set and as code 0 (read) otherwise. memCmd is valid in the cycle after acceptance, while memValid is high.
- R2: A write request (reqWrite=1) is issued as code 4 (swap) when reqSwap is set, whatever reqLocked holds. Otherwise it is issued as code 3 (store-conditional) when reqLocked is set, and as code 1 (write) when neither flag is set.
- R3: A store-conditional is issued only when the reservation is valid and its line (address shifted right by log2 of LINE_BYTES, 4 by default) equals the request's line. Otherwise memValid stays low, and in the next cycle doneValid pulses with doneSuccess=0 and doneData=0.
- R4: The reservation is invalid after any store-conditional, whether it was issued or failed locally.
- R5: An accepted request that is not squashed completes one cycle after its response: doneValid pulses with doneSuccess=1 and doneData equal to rspData. When the request is a load-linked, the reservation then holds that request's line.
- R6: If memReady is low while memValid is high, the block blocks. memValid and reqReady then stay low, even after memReady rises, until memRetry is pulsed. The command is re-presented in the cycle after the retry.
- R7: At most one request is outstanding: reqReady is low from the cycle after acceptance until the request completes or is abandoned.
- R8: reqSquash while a response is owed makes the block consume that response without a doneValid pulse and without recording a reservation. reqSquash before the command is accepted (including while blocked) abandons the request with no completion and returns reqReady high in the next cycle.
- R9: resvClear invalidates the reservation from the next cycle on. If it arrives in the same cycle as a load-linked response, the clear wins and the reservation stays invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Pipeline request present |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqLocked | input | 1 | Atomic link flag |
| reqSwap | input | 1 | Atomic swap flag (stores) |
| reqAddr | input | AW | Byte address |
| reqData | input | DW | Store data |
| reqSquash | input | 1 | Abandon the current request |
| memValid | output | 1 | Command presented to memory |
| memReady | input | 1 | Memory accepts the command |
| memCmd | output | 3 | Command code (0 read, 1 write, 2 load-linked, 3 store-conditional, 4 swap) |
| memAddr | output | AW | Command address |
| memData | output | DW | Command write data |
| memRetry | input | 1 | Memory may be tried again after a refusal |
| rspValid | input | 1 | Memory response present |
| rspData | input | DW | Response data |
| resvClear | input | 1 | External reservation invalidate |
| doneValid | output | 1 | Request completed |
| doneSuccess | output | 1 | 0 only for a failed store-conditional |
| doneData | output | DW | Returned data, 0 on local failure |

## Verification
Two functions can land in the same cycle: a load-linked response that records the reservation, and the external clear that invalidates it. The bench drives resvClear together with rspValid for a load-linked, then sends a store-conditional to the same line. That store-conditional must fail locally with no memory command, which shows that the clear took priority. A sweep over every flag combination, with offsets and lines that vary, keeps a reference model of the reservation in the bench, so store-conditionals pass and fail in many different orders.

// File: rtl/mri_pkg.sv
package mri_pkg;

  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_LL    = 3'd2,
    CMD_SC    = 3'd3,
    CMD_SWAP  = 3'd4
  } memCmdE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_BLOCK
  } issueStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic setResv;
    logic clrResv;
    logic doneOk;
    logic doneFail;
  } ctrlStrobeT;

  // swap outranks locked on stores; locked picks LL on loads
  function automatic memCmdE translateCmd(input logic isWrite,
                                          input logic locked,
                                          input logic swap);
    memCmdE c;
    if (!isWrite)   c = locked ? CMD_LL : CMD_READ;
    else if (swap)  c = CMD_SWAP;
    else if (locked) c = CMD_SC;
    else            c = CMD_WRITE;
    return c;
  endfunction

endpackage

// File: rtl/mri_ctrl.sv
module mri_ctrl
  import mri_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       reqSquash,
  input  logic       memReady,
  input  logic       memRetry,
  input  logic       rspValid,
  input  logic       isSc,
  input  logic       isLl,
  input  logic       scPass,
  output logic       memValid,
  output ctrlStrobeT strobe
);

  issueStateE state, nextState;
  logic squashedQ, nextSquashed;
  logic scFail;

  assign scFail = isSc && !scPass;

  always_comb begin
    nextState    = state;
    nextSquashed = squashedQ;
    strobe       = '0;
    reqReady     = (state == ST_IDLE);
    memValid     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          nextState      = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (reqSquash) begin
          nextState = ST_IDLE;
        end else if (scFail) begin
          strobe.doneFail = 1'b1;
          strobe.clrResv  = 1'b1;
          nextState       = ST_IDLE;
        end else begin
          memValid = 1'b1;
          if (memReady) begin
            nextState      = ST_WAIT;
            nextSquashed   = 1'b0;
            strobe.clrResv = isSc;
          end else begin
            nextState = ST_BLOCK;
          end
        end
      end
      ST_BLOCK: begin
        if (reqSquash)     nextState = ST_IDLE;
        else if (memRetry) nextState = ST_ISSUE;
      end
      ST_WAIT: begin
        if (rspValid) begin
          if (!squashedQ && !reqSquash) begin
            strobe.doneOk  = 1'b1;
            strobe.setResv = isLl;
          end
          nextSquashed = 1'b0;
          nextState    = ST_IDLE;
        end else if (reqSquash) begin
          nextSquashed = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      squashedQ <= 1'b0;
    end else begin
      state     <= nextState;
      squashedQ <= nextSquashed;
    end
  end

  // R6: a refused command is withdrawn on the next cycle
  p_refusal_withdraws_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (!memValid && !reqReady));

  // R6: no re-issue while blocked without a retry pulse
  p_no_issue_without_retry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BLOCK && !memRetry) |=> !memValid);

  // R7: accepted request closes the input side
  p_single_outstanding_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R8: a squash while waiting suppresses the completion
  p_squash_drops_rsp_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && reqSquash) |-> !strobe.doneOk);

endmodule

// File: rtl/mri_dpath.sv
module mri_dpath
  import mri_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int LINE_BYTES = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobeT    strobe,
  input  logic          reqWrite,
  input  logic          reqLocked,
  input  logic          reqSwap,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic [DW-1:0] rspData,
  input  logic          resvClear,
  output logic          isSc,
  output logic          isLl,
  output logic          scPass,
  output logic [2:0]    memCmd,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData,
  output logic          doneValid,
  output logic          doneSuccess,
  output logic [DW-1:0] doneData
);

  localparam int OFFW = $clog2(LINE_BYTES);
  localparam int LW   = AW - OFFW;

  memCmdE        cmdQ;
  logic [AW-1:0] addrQ;
  logic [DW-1:0] dataQ;
  logic          resvValidQ;
  logic [LW-1:0] resvLineQ;
  logic [LW-1:0] curLine;

  assign curLine = addrQ[AW-1:OFFW];
  assign isSc    = (cmdQ == CMD_SC);
  assign isLl    = (cmdQ == CMD_LL);
  assign scPass  = resvValidQ && (resvLineQ == curLine);
  assign memCmd  = cmdQ;
  assign memAddr = addrQ;
  assign memData = dataQ;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= CMD_READ;
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobe.loadReq) begin
      cmdQ  <= translateCmd(reqWrite, reqLocked, reqSwap);
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  // link reservation: any clear beats a set in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resvValidQ <= 1'b0;
      resvLineQ  <= '0;
    end else if (resvClear || strobe.clrResv) begin
      resvValidQ <= 1'b0;
    end else if (strobe.setResv) begin
      resvValidQ <= 1'b1;
      resvLineQ  <= curLine;
    end
  end

  // completion report
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid   <= 1'b0;
      doneSuccess <= 1'b0;
      doneData    <= '0;
    end else begin
      doneValid   <= strobe.doneOk | strobe.doneFail;
      doneSuccess <= strobe.doneOk;
      doneData    <= strobe.doneOk ? rspData : '0;
    end
  end

  // R3: local failure reports zero data and no success
  p_sc_fail_report_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doneFail |=> (doneValid && !doneSuccess && doneData == '0));

  // R4: store-conditional leaves no reservation
  p_sc_clears_resv_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrResv |=> !resvValidQ);

  // R5: load-linked completion records its line
  p_ll_records_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setResv && !resvClear) |=> (resvValidQ && resvLineQ == $past(curLine)));

  // R9: external clear always wins
  p_ext_clear_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    resvClear |=> !resvValidQ);

endmodule

// File: rtl/mem_req_issuer.sv
module mem_req_issuer
  import mri_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int LINE_BYTES = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic          reqWrite,
  input  logic          reqLocked,
  input  logic          reqSwap,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic          reqSquash,
  output logic          memValid,
  input  logic          memReady,
  output logic [2:0]    memCmd,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData,
  input  logic          memRetry,
  input  logic          rspValid,
  input  logic [DW-1:0] rspData,
  input  logic          resvClear,
  output logic          doneValid,
  output logic          doneSuccess,
  output logic [DW-1:0] doneData
);

  ctrlStrobeT strobe;
  logic isSc, isLl, scPass;

  mri_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .reqSquash(reqSquash),
    .memReady (memReady),
    .memRetry (memRetry),
    .rspValid (rspValid),
    .isSc     (isSc),
    .isLl     (isLl),
    .scPass   (scPass),
    .memValid (memValid),
    .strobe   (strobe)
  );

  mri_dpath #(.AW(AW), .DW(DW), .LINE_BYTES(LINE_BYTES)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqWrite   (reqWrite),
    .reqLocked  (reqLocked),
    .reqSwap    (reqSwap),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .rspData    (rspData),
    .resvClear  (resvClear),
    .isSc       (isSc),
    .isLl       (isLl),
    .scPass     (scPass),
    .memCmd     (memCmd),
    .memAddr    (memAddr),
    .memData    (memData),
    .doneValid  (doneValid),
    .doneSuccess(doneSuccess),
    .doneData   (doneData)
  );

  // R1: load command follows the locked flag
  p_load_cmd_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=>
      (memCmd == ($past(reqLocked) ? 3'd2 : 3'd0)));

  // R2: store command: swap, then locked, then plain
  p_store_cmd_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=>
      (memCmd == ($past(reqSwap) ? 3'd4 : ($past(reqLocked) ? 3'd3 : 3'd1))));

  // R3: a locally failed completion never follows an issue
  p_fail_without_issue_r3: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !doneSuccess) |-> !$past(memValid));

endmodule

// File: tb/sim_mem_req_issuer.sv
module sim_mem_req_issuer;

  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0, reqLocked = 1'b0, reqSwap = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic          reqSquash = 1'b0, memReady = 1'b1, memRetry = 1'b0;
  logic          rspValid = 1'b0, resvClear = 1'b0;
  logic [DW-1:0] rspData = '0;
  logic          reqReady, memValid, doneValid, doneSuccess;
  logic [2:0]    memCmd;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData, doneData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // reference reservation
  bit        mResvV = 1'b0;
  logic [11:0] mLine = '0;

  always #10 clk = ~clk;

  mem_req_issuer #(.AW(AW), .DW(DW), .LINE_BYTES(16)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqLocked(reqLocked), .reqSwap(reqSwap),
    .reqAddr(reqAddr), .reqData(reqData), .reqSquash(reqSquash),
    .memValid(memValid), .memReady(memReady), .memCmd(memCmd),
    .memAddr(memAddr), .memData(memData), .memRetry(memRetry),
    .rspValid(rspValid), .rspData(rspData), .resvClear(resvClear),
    .doneValid(doneValid), .doneSuccess(doneSuccess), .doneData(doneData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] expCmd(input logic w, input logic l, input logic s);
    if (!w) return l ? 3'd2 : 3'd0;
    if (s)  return 3'd4;
    return l ? 3'd3 : 3'd1;
  endfunction

  task automatic present(input logic w, input logic l, input logic s,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    check("R7 ready before request", reqReady, 1);
    reqValid = 1; reqWrite = w; reqLocked = l; reqSwap = s; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 0;
  endtask

  // full transaction with memReady high; clrAtRsp drives resvClear with the response
  task automatic txn(input logic w, input logic l, input logic s,
                     input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [DW-1:0] rsp, input bit clrAtRsp);
    logic [2:0] c;
    bit issue;
    c = expCmd(w, l, s);
    issue = !(c == 3'd3 && !(mResvV && mLine == a[AW-1:4]));
    present(w, l, s, a, d);
    if (issue) begin
      check("R1/R2 memValid", memValid, 1);
      check((w ? "R2 command" : "R1 command"), memCmd, c);
      check("R1 address", memAddr, a);
      if (w) check("R2 data", memData, d);
      if (c == 3'd3) mResvV = 0;
      @(negedge clk);
      check("R7 busy while waiting", reqReady, 0);
      rspValid = 1; rspData = rsp; resvClear = clrAtRsp;
      @(negedge clk);
      rspValid = 0; resvClear = 0;
      check("R5 doneValid", doneValid, 1);
      check((c == 3'd3 ? "R3 sc success" : "R5 success"), doneSuccess, 1);
      check("R5 doneData", doneData, rsp);
      if (clrAtRsp) mResvV = 0;
      else if (c == 3'd2) begin mResvV = 1; mLine = a[AW-1:4]; end
    end else begin
      check("R3 no issue on failed sc", memValid, 0);
      mResvV = 0;
      @(negedge clk);
      check("R3 local completion", doneValid, 1);
      check("R3 failure flag", doneSuccess, 0);
      check("R3 zero data", doneData, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R7 reset ready", reqReady, 1);
    check("R6 reset memValid", memValid, 0);
    check("R5 reset doneValid", doneValid, 0);

    // sweep of flag combinations, offsets and lines
    for (int i = 0; i < 64; i++) begin
      logic [AW-1:0] a;
      a = 16'h0200 + ((((i * 7) >> 3) & 1) * 16) + (i & 15);
      txn(i[0], i[1], i[2], a, 16'h1000 + i, (i * 16'h1111) ^ 16'h5a5a, 1'b0);
    end

    // R3/R5: LL then SC same line passes, second SC fails (R4)
    txn(0, 1, 0, 16'h0340, 0, 16'hbeef, 0);
    txn(1, 1, 0, 16'h034c, 16'h7777, 16'h0001, 0);
    txn(1, 1, 0, 16'h0344, 16'h7777, 16'h0002, 0);
    // R3: other line fails
    txn(0, 1, 0, 16'h0340, 0, 16'h1234, 0);
    txn(1, 1, 0, 16'h0350, 16'h1, 16'h2, 0);
    // R9: clear while idle
    txn(0, 1, 0, 16'h0360, 0, 16'h4321, 0);
    @(negedge clk); resvClear = 1; @(negedge clk); resvClear = 0; mResvV = 0;
    txn(1, 1, 0, 16'h0360, 16'h9, 16'h9, 0);
    // R9: clear collides with LL response, clear wins
    txn(0, 1, 0, 16'h0370, 0, 16'h5555, 1);
    txn(1, 1, 0, 16'h0370, 16'h3, 16'h3, 0);

    // R6: refusal, blocked until retry
    memReady = 0;
    present(0, 0, 0, 16'h0400, 0);
    check("R6 offered", memValid, 1);
    @(negedge clk);
    check("R6 withdrawn when blocked", memValid, 0);
    check("R6 not ready when blocked", reqReady, 0);
    memReady = 1;
    @(negedge clk);
    check("R6 no issue without retry", memValid, 0);
    check("R6 no completion while blocked", doneValid, 0);
    memRetry = 1;
    @(negedge clk);
    memRetry = 0;
    check("R6 reissue after retry", memValid, 1);
    check("R6 same command", memCmd, 0);
    @(negedge clk);
    rspValid = 1; rspData = 16'hcafe;
    @(negedge clk);
    rspValid = 0;
    check("R6 completes after retry", doneValid, 1);
    check("R6 data after retry", doneData, 16'hcafe);

    // R8: squash while blocked
    memReady = 0;
    present(1, 0, 0, 16'h0410, 16'h1);
    @(negedge clk);
    reqSquash = 1;
    @(negedge clk);
    reqSquash = 0;
    memReady = 1;
    check("R8 abandon returns ready", reqReady, 1);
    check("R8 abandon no completion", doneValid, 0);
    check("R8 abandon no issue", memValid, 0);

    // R8: squash while waiting on an LL; response dropped, no reservation
    @(negedge clk); resvClear = 1; @(negedge clk); resvClear = 0; mResvV = 0;
    present(0, 1, 0, 16'h0480, 0);
    check("R8 LL issued", memValid, 1);
    @(negedge clk);
    reqSquash = 1;
    @(negedge clk);
    reqSquash = 0;
    rspValid = 1; rspData = 16'h6666;
    check("R8 still waiting", reqReady, 0);
    @(negedge clk);
    rspValid = 0;
    check("R8 dropped response", doneValid, 0);
    check("R8 ready after drop", reqReady, 1);
    txn(1, 1, 0, 16'h0480, 16'h8, 16'h8, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule